// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is an eight-bit (parameterised) storage register that can hold its value, shift toward its high end, shift toward its low end, or take a new parallel word on a clock edge. Two function-select inputs pick the operation. Parallel data goes in and out through one set of shared bidirectional pads. Each pad is modelled as a separate input bit, output bit and output-enable, so the design stays synthesizable. The pad drivers stay on only while both active-low enables are asserted and the block is not loading. During a load they are forced off, so an external source can present the word that gets captured.

Two serial inputs, one for each shift direction, and two always-driven end-bit outputs let several of these registers be chained into longer words. The end-bit outputs keep working while the shared pads are released. An active-low clear resets the register at any time and overrides the clock and every other input.

Top module: `ushift_mux_io`

## Requirements
- R1: With mode code {sel_hi,sel_lo} = 00 (hold), the register keeps its value across a clock edge.
- R2: With mode code 01 (shift up), on a clock edge bit 0 takes ser_up_in and each bit i>0 takes the old bit i-1.
- R3: With mode code 10 (shift down), on a clock edge bit WIDTH-1 takes ser_down_in and each bit i<WIDTH-1 takes the old bit i+1.
- R4: With mode code 11 (load), on a clock edge the register takes the value on pad_in.
- R5: While the mode code is 11, pad_oe is 0 whatever the two enables say.
- R6: pad_oe is 1 exactly when en_a_n and en_b_n are both 0 and the mode code is not 11. It follows these inputs combinationally.
- R7: When clr_n is low, the register becomes all zeros at once, without waiting for a clock edge. It stays zero through clock edges in any mode until clr_n rises.
- R8: end_lo always equals register bit 0 and end_hi always equals bit WIDTH-1, independent of the enables.
- R9: pad_out always carries the register contents. Hold, shift and load behave the same whether pad_oe is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel_lo | input | 1 | Mode select, low bit |
| sel_hi | input | 1 | Mode select, high bit |
| en_a_n | input | 1 | First pad-drive enable, active low |
| en_b_n | input | 1 | Second pad-drive enable, active low |
| ser_up_in | input | 1 | Serial data entering bit 0 when shifting up |
| ser_down_in | input | 1 | Serial data entering the top bit when shifting down |
| pad_in | input | WIDTH | Value seen on the shared pads |
| pad_out | output | WIDTH | Value the block drives onto the pads |
| pad_oe | output | 1 | Pad driver enable |
| end_lo | output | 1 | Bit 0 of the register, for chaining |
| end_hi | output | 1 | Top bit of the register, for chaining |

## Verification
The register, and with it pad_out, end_lo and end_hi, changes on the first rising edge after the mode and data are applied. The bench drives each stimulus at a falling edge and compares against its own arithmetic model at the next falling edge, one full cycle later. pad_oe depends only on the current inputs, so the bench checks it one nanosecond after driving, before any edge. The clear has no clock latency: its effect is checked one nanosecond after clr_n falls mid-cycle, and again after an edge taken with a load pending.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
`timescale 1ns/1ps
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic        sel_lo,
  input  logic        sel_hi,
  output shift_mode_e mode,
  output logic        is_load
);
  always_comb begin
    mode    = shift_mode_e'({sel_hi, sel_lo});
    is_load = (mode == MODE_LOAD);
  end
endmodule

// File: rtl/usr_pad_ctrl.sv
`timescale 1ns/1ps
module usr_pad_ctrl (
  input  logic en_a_n,
  input  logic en_b_n,
  input  logic is_load,
  output logic pad_oe
);
  // Drivers turn on only when both enables are asserted and no load is underway
  assign pad_oe = ~en_a_n & ~en_b_n & ~is_load;
endmodule

// File: rtl/usr_stage_cell.sv
`timescale 1ns/1ps
module usr_stage_cell
  import usr_pkg::*;
(
  input  logic        clk,
  input  logic        clr_n,
  input  shift_mode_e mode,
  input  logic        from_lower,
  input  logic        from_upper,
  input  logic        par_bit,
  output logic        q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_HOLD: q <= q;
        MODE_UP:   q <= from_lower;
        MODE_DOWN: q <= from_upper;
        MODE_LOAD: q <= par_bit;
      endcase
    end
  end
endmodule

// File: rtl/ushift_mux_io.sv
`timescale 1ns/1ps
module ushift_mux_io
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             ser_up_in,
  input  logic             ser_down_in,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic             pad_oe,
  output logic             end_lo,
  output logic             end_hi
);
  localparam int TOP = WIDTH - 1;

  shift_mode_e      mode;
  logic             is_load;
  logic [WIDTH-1:0] q;

  usr_mode_dec u_dec (
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi),
    .mode    (mode),
    .is_load (is_load)
  );

  usr_pad_ctrl u_pad (
    .en_a_n  (en_a_n),
    .en_b_n  (en_b_n),
    .is_load (is_load),
    .pad_oe  (pad_oe)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic lower_src;
    logic upper_src;
    if (i == 0) begin : g_first
      assign lower_src = ser_up_in;
    end else begin : g_mid_lo
      assign lower_src = q[i-1];
    end
    if (i == TOP) begin : g_last
      assign upper_src = ser_down_in;
    end else begin : g_mid_hi
      assign upper_src = q[i+1];
    end
    usr_stage_cell u_cell (
      .clk        (clk),
      .clr_n      (clr_n),
      .mode       (mode),
      .from_lower (lower_src),
      .from_upper (upper_src),
      .par_bit    (pad_in[i]),
      .q          (q[i])
    );
  end

  assign pad_out = q;
  assign end_lo  = q[0];
  assign end_hi  = q[TOP];

  // R1: hold keeps contents
  assert_hold_keeps_R1: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel_hi, sel_lo} == 2'b00) |=> (pad_out == $past(pad_out)));
  // R2: shift up
  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel_hi, sel_lo} == 2'b01) |=> (pad_out == {$past(pad_out[TOP-1:0]), $past(ser_up_in)}));
  // R3: shift down
  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel_hi, sel_lo} == 2'b10) |=> (pad_out == {$past(ser_down_in), $past(pad_out[TOP:1])}));
  // R4: parallel capture
  assert_load_capture_R4: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel_hi, sel_lo} == 2'b11) |=> (pad_out == $past(pad_in)));
  // R5: drivers off during load
  assert_load_hiz_R5: assert property (@(posedge clk)
    (sel_hi && sel_lo) |-> !pad_oe);
  // R6: drivers on when both enables asserted outside load
  assert_drive_on_R6: assert property (@(posedge clk)
    (!en_a_n && !en_b_n && !(sel_hi && sel_lo)) |-> pad_oe);
  // R7: clear holds register at zero
  assert_clear_zero_R7: assert property (@(posedge clk)
    !clr_n |-> (pad_out == '0));
endmodule

// File: tb/ushift_mux_io_tb_top.sv
`timescale 1ns/1ps
module ushift_mux_io_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n, sel_lo, sel_hi, en_a_n, en_b_n, ser_up_in, ser_down_in;
  logic [W-1:0] pad_in, pad_out;
  logic         pad_oe, end_lo, end_hi;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  ushift_mux_io #(.WIDTH(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .ser_up_in(ser_up_in),
    .ser_down_in(ser_down_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .end_lo(end_lo), .end_hi(end_hi)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, check pad_oe, clock once, check state at the next falling edge
  task automatic step(input logic [1:0] m, input logic ea, input logic eb,
                      input logic su, input logic sd, input logic [W-1:0] pin);
    logic [W-1:0] nxt;
    logic         oe_exp;
    {sel_hi, sel_lo} = m;
    en_a_n = ea; en_b_n = eb; ser_up_in = su; ser_down_in = sd; pad_in = pin;
    #1;
    oe_exp = !ea && !eb && (m != 2'b11);
    if (m == 2'b11) chk("R5 load forces drivers off", {7'd0, pad_oe}, 8'd0);
    else            chk("R6 driver enable", {7'd0, pad_oe}, {7'd0, oe_exp});
    case (m)
      2'b00: nxt = model;
      2'b01: nxt = {model[W-2:0], su};
      2'b10: nxt = {sd, model[W-1:1]};
      default: nxt = pin;
    endcase
    @(negedge clk);
    model = nxt;
    case (m)
      2'b00: chk(oe_exp ? "R1 hold" : "R1 R9 hold, drivers off", pad_out, model);
      2'b01: chk(oe_exp ? "R2 shift up" : "R2 R9 shift up, drivers off", pad_out, model);
      2'b10: chk(oe_exp ? "R3 shift down" : "R3 R9 shift down, drivers off", pad_out, model);
      default: chk("R4 R9 load", pad_out, model);
    endcase
    chk("R8 end bits", {6'd0, end_hi, end_lo}, {6'd0, model[W-1], model[0]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr_n = 0; sel_lo = 0; sel_hi = 0; en_a_n = 0; en_b_n = 0;
    ser_up_in = 0; ser_down_in = 0; pad_in = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset state", pad_out, '0);
    chk("R8 reset end bits", {6'd0, end_hi, end_lo}, 8'd0);
    clr_n = 1;
    @(negedge clk);

    // Exhaustive parallel load over every word, each followed by a hold with enables off
    for (int v = 0; v < 256; v++) begin
      step(2'b11, v[0], v[1], v[2], v[3], W'(v));
      step(2'b00, 1'b1, v[4], v[5], v[6], W'(v * 37 + 11));
    end

    // Sweep modes x enables x serial bits from many starting words
    for (int s = 0; s < 64; s++) begin
      step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, W'(s * 73 + 5));
      for (int c = 0; c < 64; c++) begin
        step(c[1:0], c[2], c[3], c[4] ^ s[0], c[5] ^ s[1], W'(c * 29 + s));
      end
    end

    // Full walk up then down with serial inputs, drivers released
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < W; k++) step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF);
    chk("R2 filled by serial up", pad_out, 8'hFF);
    for (int k = 0; k < W; k++) step(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    chk("R3 drained by serial down", pad_out, 8'h00);

    // Asynchronous clear mid-cycle, then priority over a pending load
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    sel_hi = 1; sel_lo = 1; pad_in = 8'h3C;
    #2 clr_n = 0;
    #1 chk("R7 clear without clock", pad_out, '0);
    chk("R8 end bits after clear", {6'd0, end_hi, end_lo}, 8'd0);
    @(negedge clk);
    chk("R7 clear beats load", pad_out, '0);
    sel_hi = 0; sel_lo = 1; ser_up_in = 1;
    @(negedge clk);
    chk("R7 clear beats shift", pad_out, '0);
    clr_n = 1;
    model = '0;
    step(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R2 first shift after clear", pad_out, 8'h01);

    finish_run();
  end
endmodule